// File: doc/BRIEF.md
# SD Host Interrupt Status Controller

This block holds the interrupt bookkeeping of an SD host controller. The command, data, DMA and card-detect engines report events as single-cycle pulses on a 32-bit event bus whose bit positions are fixed by the SD host bit map. Each event can be latched into a status register. A status-enable register decides whether an event is latched at all. A separate signal-enable register decides whether a latched bit drives the single level-sensitive interrupt line towards the processor.

Software reads any of the three registers through a select-addressed read port. It writes the two enable registers directly. It acknowledges status bits by writing ones to the status register. The card interrupt from an SDIO card is treated as a level, not a pulse: its status bit tracks the card's request while enabled. An error summary output is high whenever any error-group status bit is latched, so that recovery logic can react without decoding the status word.

Top module: `sdhost_irq_ctrl`

## Requirements
- R1: After reset the status, status-enable and signal-enable registers all read zero, and `irq_o` and `err_o` are low.
- R2: A pulse on a normal event bit sets its status bit at the next clock edge when its status-enable bit is set. The normal bits are: command complete 0, transfer complete 1, block-gap 2, DMA interrupt 3, buffer write ready 4, buffer read ready 5, card inserted 6, card removed 7.
- R3: Error events latch in the same way at these positions: command timeout 16, command CRC 17, command end-bit 18, command index 19, data timeout 20, data CRC 21, data end-bit 22, DMA error 28.
- R4: An event whose status-enable bit is clear is ignored and leaves the status register unchanged.
- R5: Writing the status register (select 0) clears each status bit written as one. Bits written as zero keep their value.
- R6: If an enabled event and a clearing write hit the same bit in the same cycle, the bit is set after that edge.
- R7: Status bit 8 (card interrupt) equals, one edge later, `card_irq_i` AND status-enable bit 8. Writing one to it does not clear it while the request is held, and event bus bit 8 has no effect.
- R8: `irq_o` is high exactly when some status bit is set whose signal-enable bit is also set.
- R9: `err_o` is high exactly when at least one status bit of the error group (bits 16 to 22 and 28) is set.
- R10: Only bits 0 to 8, 16 to 22 and 28 exist. All other bits of all three registers read zero and cannot be set by writes or events.
- R11: Select codes are: 0 status, 1 status-enable, 2 signal-enable. A write with select 3 changes nothing, and select 3 reads zero.
- R12: Clearing a status-enable bit keeps an already latched status bit set until software clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| evt_i | input | 32 | One-cycle event pulses, positioned by the bit map |
| card_irq_i | input | 1 | Level interrupt request from the card |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 2 | Register selected for writing |
| wr_data_i | input | 32 | Write data |
| rd_sel_i | input | 2 | Register selected for reading |
| rd_data_o | output | 32 | Read data, combinational from `rd_sel_i` |
| irq_o | output | 1 | Level interrupt line |
| err_o | output | 1 | Error-group summary |

## Verification
The hardest situation to reach is an enabled event landing on a bit in the very cycle that software writes a one to clear it. That collision decides whether an acknowledgement can swallow a fresh event. Directed steps force this collision on a normal bit and on the held card request. Long random runs then combine sparse event pulses with frequent random clear and enable writes, so that such collisions, as well as enables that change under latched bits, occur many times across all implemented bits. Each run is compared against a bench reference model.

// File: rtl/sdhost_irq_pkg.sv
package sdhost_irq_pkg;

    localparam int REG_W = 32;
    localparam int SEL_W = 2;

    typedef enum logic [SEL_W-1:0] {
        SEL_STATUS  = 2'd0,
        SEL_STAT_EN = 2'd1,
        SEL_SIG_EN  = 2'd2,
        SEL_NONE    = 2'd3
    } reg_sel_e;

    // normal event positions
    localparam int B_CMD_DONE  = 0;
    localparam int B_XFER_DONE = 1;
    localparam int B_BLK_GAP   = 2;
    localparam int B_DMA_EVT   = 3;
    localparam int B_WBUF_RDY  = 4;
    localparam int B_RBUF_RDY  = 5;
    localparam int B_CARD_IN   = 6;
    localparam int B_CARD_OUT  = 7;
    localparam int B_CARD_INT  = 8;
    // error event positions
    localparam int B_CMD_TMO   = 16;
    localparam int B_CMD_CRC   = 17;
    localparam int B_CMD_END   = 18;
    localparam int B_CMD_IDX   = 19;
    localparam int B_DAT_TMO   = 20;
    localparam int B_DAT_CRC   = 21;
    localparam int B_DAT_END   = 22;
    localparam int B_DMA_ERR   = 28;

    localparam logic [REG_W-1:0] ONE = {{(REG_W-1){1'b0}}, 1'b1};

    localparam logic [REG_W-1:0] NORMAL_MASK =
        (ONE << B_CMD_DONE) | (ONE << B_XFER_DONE) | (ONE << B_BLK_GAP) |
        (ONE << B_DMA_EVT)  | (ONE << B_WBUF_RDY)  | (ONE << B_RBUF_RDY) |
        (ONE << B_CARD_IN)  | (ONE << B_CARD_OUT);

    localparam logic [REG_W-1:0] ERR_MASK =
        (ONE << B_CMD_TMO) | (ONE << B_CMD_CRC) | (ONE << B_CMD_END) |
        (ONE << B_CMD_IDX) | (ONE << B_DAT_TMO) | (ONE << B_DAT_CRC) |
        (ONE << B_DAT_END) | (ONE << B_DMA_ERR);

    localparam logic [REG_W-1:0] LEVEL_MASK = ONE << B_CARD_INT;
    localparam logic [REG_W-1:0] PULSE_MASK = NORMAL_MASK | ERR_MASK;
    localparam logic [REG_W-1:0] IMPL_MASK  = PULSE_MASK | LEVEL_MASK;

endpackage

// File: rtl/sdhost_irq_enable.sv
module sdhost_irq_enable
    import sdhost_irq_pkg::*;
#(
    parameter logic [SEL_W-1:0] MY_SEL = SEL_STAT_EN
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en_i,
    input  logic [SEL_W-1:0] wr_sel_i,
    input  logic [REG_W-1:0] wr_data_i,
    output logic [REG_W-1:0] en_o
);

    typedef struct packed {
        logic [REG_W-1:0] en;
    } en_state_t;

    en_state_t st_d, st_q;
    logic      hit;

    always_comb begin
        st_d = st_q;
        hit  = wr_en_i && (wr_sel_i == MY_SEL);
        if (hit) begin
            st_d.en = wr_data_i & IMPL_MASK;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign en_o = st_q.en;

    // R11
    hold_when_unselected_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en_i && (wr_sel_i == MY_SEL)) |=> $stable(en_o));

endmodule

// File: rtl/sdhost_irq_status.sv
module sdhost_irq_status
    import sdhost_irq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [REG_W-1:0] evt_i,
    input  logic             card_irq_i,
    input  logic [REG_W-1:0] sten_i,
    input  logic [REG_W-1:0] clr_i,
    output logic [REG_W-1:0] sta_o
);

    typedef struct packed {
        logic [REG_W-1:0] sta;
    } sta_state_t;

    sta_state_t st_d, st_q;
    logic [REG_W-1:0] nxt;

    logic unused_sink;
    assign unused_sink = ^{evt_i & ~PULSE_MASK, clr_i & ~PULSE_MASK, sten_i & ~IMPL_MASK};

    for (genvar k = 0; k < REG_W; k++) begin : g_bit
        if (LEVEL_MASK[k]) begin : g_level
            // level bit: tracks request, acknowledge cannot drop it
            always_comb nxt[k] = card_irq_i & sten_i[k];

            // R7
            card_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
                1'b1 |=> (sta_o[k] == $past(card_irq_i && sten_i[k])));
        end else if (PULSE_MASK[k]) begin : g_pulse
            // set has priority over clear
            always_comb nxt[k] = (st_q.sta[k] & ~clr_i[k]) | (evt_i[k] & sten_i[k]);

            // R2 R3 R4
            rise_needs_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
                $rose(sta_o[k]) |-> $past(evt_i[k] && sten_i[k]));
            // R6
            event_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (evt_i[k] && sten_i[k]) |=> sta_o[k]);
            // R5
            clear_works_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (clr_i[k] && !(evt_i[k] && sten_i[k])) |=> !sta_o[k]);
        end else begin : g_none
            always_comb nxt[k] = 1'b0;
        end
    end

    always_comb begin
        st_d     = st_q;
        st_d.sta = nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sta_o = st_q.sta;

endmodule

// File: rtl/sdhost_irq_out.sv
module sdhost_irq_out
    import sdhost_irq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [REG_W-1:0] sta_i,
    input  logic [REG_W-1:0] sten_i,
    input  logic [REG_W-1:0] sig_i,
    input  logic [SEL_W-1:0] rd_sel_i,
    output logic [REG_W-1:0] rd_data_o,
    output logic             irq_o,
    output logic             err_o
);

    always_comb begin
        irq_o = |(sta_i & sig_i);
        err_o = |(sta_i & ERR_MASK);
        unique case (rd_sel_i)
            SEL_STATUS:  rd_data_o = sta_i;
            SEL_STAT_EN: rd_data_o = sten_i;
            SEL_SIG_EN:  rd_data_o = sig_i;
            default:     rd_data_o = '0;
        endcase
    end

    // R8
    irq_needs_sig_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sig_i == '0) |-> !irq_o);
    // R9
    err_ignores_normal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((sta_i & ERR_MASK) == '0) |-> !err_o);

endmodule

// File: rtl/sdhost_irq_ctrl.sv
module sdhost_irq_ctrl
    import sdhost_irq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [31:0]      evt_i,
    input  logic             card_irq_i,
    input  logic             wr_en_i,
    input  logic [1:0]       wr_sel_i,
    input  logic [31:0]      wr_data_i,
    input  logic [1:0]       rd_sel_i,
    output logic [31:0]      rd_data_o,
    output logic             irq_o,
    output logic             err_o
);

    logic [REG_W-1:0] sten_q;
    logic [REG_W-1:0] sig_q;
    logic [REG_W-1:0] sta_q;
    logic [REG_W-1:0] clr;

    assign clr = (wr_en_i && (wr_sel_i == SEL_STATUS)) ? wr_data_i : '0;

    sdhost_irq_enable #(.MY_SEL(SEL_STAT_EN)) u_stat_en (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (wr_en_i),
        .wr_sel_i  (wr_sel_i),
        .wr_data_i (wr_data_i),
        .en_o      (sten_q)
    );

    sdhost_irq_enable #(.MY_SEL(SEL_SIG_EN)) u_sig_en (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (wr_en_i),
        .wr_sel_i  (wr_sel_i),
        .wr_data_i (wr_data_i),
        .en_o      (sig_q)
    );

    sdhost_irq_status u_status (
        .clk        (clk),
        .rst_n      (rst_n),
        .evt_i      (evt_i),
        .card_irq_i (card_irq_i),
        .sten_i     (sten_q),
        .clr_i      (clr),
        .sta_o      (sta_q)
    );

    sdhost_irq_out u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .sta_i     (sta_q),
        .sten_i    (sten_q),
        .sig_i     (sig_q),
        .rd_sel_i  (rd_sel_i),
        .rd_data_o (rd_data_o),
        .irq_o     (irq_o),
        .err_o     (err_o)
    );

    // R12
    latched_survives_disable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sta_q[2] && !clr[2]) |=> sta_q[2]);

endmodule

// File: tb/sdhost_irq_ctrl_tb.sv
module sdhost_irq_ctrl_tb;

    localparam int CLK_PERIOD = 10;
    localparam logic [31:0] M_IMPL  = 32'h107F_01FF;
    localparam logic [31:0] M_ERR   = 32'h107F_0000;
    localparam logic [31:0] M_PULSE = 32'h107F_00FF;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] evt = '0;
    logic        card = 1'b0;
    logic        wen = 1'b0;
    logic [1:0]  wsel = '0;
    logic [31:0] wdata = '0;
    logic [1:0]  rsel = '0;
    logic [31:0] rdata;
    logic        irq, err;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [31:0] m_sta = '0, m_sten = '0, m_sig = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sdhost_irq_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .evt_i(evt), .card_irq_i(card),
        .wr_en_i(wen), .wr_sel_i(wsel), .wr_data_i(wdata),
        .rd_sel_i(rsel), .rd_data_o(rdata), .irq_o(irq), .err_o(err)
    );

    function automatic logic [31:0] next_sta(logic [31:0] sta, logic [31:0] sten,
                                             logic [31:0] e, logic c, logic we,
                                             logic [1:0] ws, logic [31:0] wd);
        logic [31:0] clr_m, r;
        clr_m = (we && ws == 2'd0) ? wd : 32'h0;
        r = ((sta & ~clr_m) | (e & sten)) & M_PULSE;
        r[8] = c & sten[8];
        return r;
    endfunction

    task automatic model_step();
        logic [31:0] ns;
        ns = next_sta(m_sta, m_sten, evt, card, wen, wsel, wdata);
        if (wen && wsel == 2'd1) m_sten = wdata & M_IMPL;
        if (wen && wsel == 2'd2) m_sig  = wdata & M_IMPL;
        m_sta = ns;
    endtask

    task automatic chk(logic [31:0] act, logic [31:0] exp, string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
        end
    endtask

    task automatic read_reg(int s, output logic [31:0] v);
        rsel = 2'(s);
        #1;
        v = rdata;
    endtask

    // compare every observable against the model (called at negedge)
    task automatic check_all();
        logic [31:0] v;
        read_reg(0, v); chk(v, m_sta,  "R2 R3 R4 R5 R6 R7 R10 R12 status");
        read_reg(1, v); chk(v, m_sten, "R10 R11 status-enable");
        read_reg(2, v); chk(v, m_sig,  "R10 R11 signal-enable");
        read_reg(3, v); chk(v, 32'h0,  "R11 select 3 read");
        chk({31'h0, irq}, {31'h0, |(m_sta & m_sig)}, "R8 irq");
        chk({31'h0, err}, {31'h0, |(m_sta & M_ERR)}, "R9 err");
    endtask

    // apply one cycle of stimulus from a negedge to the next negedge
    task automatic cyc(logic [31:0] e, logic c, logic we, logic [1:0] ws, logic [31:0] wd);
        evt = e; card = c; wen = we; wsel = ws; wdata = wd;
        @(posedge clk);
        model_step();
        @(negedge clk);
        evt = '0; wen = 1'b0;
    endtask

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        // R1 reset state
        read_reg(0, v); chk(v, 32'h0, "R1 status after reset");
        read_reg(1, v); chk(v, 32'h0, "R1 status-enable after reset");
        read_reg(2, v); chk(v, 32'h0, "R1 signal-enable after reset");
        chk({31'h0, irq}, 32'h0, "R1 irq after reset");
        chk({31'h0, err}, 32'h0, "R1 err after reset");
        rst_n = 1'b1;
        @(negedge clk);

        // R4: events with nothing enabled are ignored
        cyc(32'hFFFF_FFFF, 1'b1, 1'b0, 2'd0, 32'h0);
        read_reg(0, v); chk(v, 32'h0, "R4 disabled events ignored");
        card = 1'b0;

        // R10 R11: enable writes keep only implemented bits
        cyc(32'h0, 1'b0, 1'b1, 2'd1, 32'hFFFF_FFFF);
        read_reg(1, v); chk(v, 32'h107F_01FF, "R10 status-enable implemented bits");
        cyc(32'h0, 1'b0, 1'b1, 2'd2, 32'hFFFF_FFFF);
        read_reg(2, v); chk(v, 32'h107F_01FF, "R10 signal-enable implemented bits");

        // R2: command complete at bit 0
        cyc(32'h0000_0001, 1'b0, 1'b0, 2'd0, 32'h0);
        read_reg(0, v); chk(v, 32'h0000_0001, "R2 bit0 latched");
        chk({31'h0, irq}, 32'h1, "R8 irq with bit0");
        chk({31'h0, err}, 32'h0, "R9 no error from normal bit");

        // R3: data timeout at bit 20
        cyc(32'h0010_0000, 1'b0, 1'b0, 2'd0, 32'h0);
        read_reg(0, v); chk(v, 32'h0010_0001, "R3 bit20 latched");
        chk({31'h0, err}, 32'h1, "R9 err with bit20");

        // R6: clear and event on bit0 together, event wins; bit20 clears
        cyc(32'h0000_0001, 1'b0, 1'b1, 2'd0, 32'h0010_0001);
        read_reg(0, v); chk(v, 32'h0000_0001, "R6 event beats clear");

        // R5: zero write keeps, one write clears
        cyc(32'h0000_0002, 1'b0, 1'b0, 2'd0, 32'h0);
        cyc(32'h0, 1'b0, 1'b1, 2'd0, 32'h0);
        read_reg(0, v); chk(v, 32'h0000_0003, "R5 zero write keeps bits");
        cyc(32'h0, 1'b0, 1'b1, 2'd0, 32'h0000_0001);
        read_reg(0, v); chk(v, 32'h0000_0002, "R5 one write clears bit0");

        // R7: card interrupt level
        cyc(32'h0, 1'b1, 1'b0, 2'd0, 32'h0);
        read_reg(0, v); chk(v & 32'h100, 32'h100, "R7 card level latched");
        cyc(32'h0, 1'b1, 1'b1, 2'd0, 32'h0000_0100);
        read_reg(0, v); chk(v & 32'h100, 32'h100, "R7 clear ignored while held");
        cyc(32'h0000_0100, 1'b0, 1'b0, 2'd0, 32'h0);
        read_reg(0, v); chk(v & 32'h100, 32'h0, "R7 event bit8 ignored, follows level");

        // R12: disabling status-enable keeps latched bit
        cyc(32'h0000_0004, 1'b0, 1'b0, 2'd0, 32'h0);
        cyc(32'h0, 1'b0, 1'b1, 2'd1, 32'h0);
        cyc(32'h0, 1'b0, 1'b0, 2'd0, 32'h0);
        read_reg(0, v); chk(v & 32'h4, 32'h4, "R12 latched bit survives disable");

        // R11: select 3 write changes nothing
        cyc(32'h0, 1'b0, 1'b1, 2'd3, 32'hFFFF_FFFF);
        check_all();

        // random phase
        void'($urandom(32'h5D1C_0A77));
        for (int i = 0; i < 4000; i++) begin
            logic [31:0] e, wd;
            logic we;
            e  = $urandom & $urandom & $urandom;
            wd = $urandom;
            we = ($urandom % 10) < 3;
            cyc(e, ($urandom % 4) == 0, we, 2'($urandom % 4), wd);
            check_all();
        end

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog R1 actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule